// File: doc/BRIEF.md
# Two-Phase Word Interleaver

This block narrows a wide acquisition word onto a bus half its width. It runs on the doubled clock. Every second cycle is an acquisition slot. In that slot it samples one input word of 2×HALF_W bits, along with a valid bit and a control/data select. Over the next two cycles it drives the low half and then the high half of that word on the narrow bus. A half-select flag travels with each half, so that a receiver at the far end can put the word back together. A qualifier pair goes to a downstream serializer:
- "data available" for a valid data word.
- "control available" for a valid control word.
- Neither, when no word is valid, so that the serializer fills the gap with idle frames.

The acquisition clock is not an input. The block keeps its own slot phase and shows it on `slot_open`, which upstream logic uses to present a new word in time for the sampling edge. The block does no clock generation, line coding or serialization.

Top module: `df_interleaver`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the block enters its reset state: `tx_half` = 0, `tx_flag` = 0, `tx_dav` = 0, `tx_cav` = 0 and `slot_open` = 1.
- R2: On a rising edge where `slot_open` is 1, the block samples `acq_word`. From that edge, `tx_half` carries `acq_word[HALF_W-1:0]` and `tx_flag` is 0.
- R3: On the next edge, `tx_half` carries `acq_word[2*HALF_W-1:HALF_W]` as sampled at the slot edge, and `tx_flag` is 1. Values on `acq_word`, `acq_valid` and `acq_ctrl` while `slot_open` is 0 have no effect on any output.
- R4: Outside reset, `slot_open` alternates 1, 0, 1, … every cycle. After the first edge following reset, `tx_flag` equals `slot_open`.
- R5: `tx_dav` is 1 for both halves of a word sampled with `acq_valid`=1 and `acq_ctrl`=0, and 0 otherwise.
- R6: `tx_cav` is 1 for both halves of a word sampled with `acq_valid`=1 and `acq_ctrl`=1, and 0 otherwise.
- R7: A word sampled with `acq_valid`=0 drives both `tx_dav` and `tx_cav` to 0 whatever `acq_ctrl` is. The two qualifiers are never 1 together.
- R8: A reset applied between the two halves of a word drops the pending high half. The first half output after reset is the low half of the next sampled word, with `tx_flag` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Doubled-rate clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| acq_word | input | 2*HALF_W | Acquisition word, sampled in slot cycles |
| acq_valid | input | 1 | Word present in this slot |
| acq_ctrl | input | 1 | 1 = control word, 0 = data word |
| slot_open | output | 1 | 1 when the next edge samples the input |
| tx_half | output | HALF_W | Narrow output bus |
| tx_flag | output | 1 | 0 = low half on bus, 1 = high half |
| tx_dav | output | 1 | Data word qualifier |
| tx_cav | output | 1 | Control word qualifier |

## Verification
Every output is registered once. The low half, its flag and its qualifiers therefore appear one edge after the slot edge that sampled them, and the high half appears one edge after that. `slot_open` changes at each edge.

The bench drives inputs on the falling edge and samples outputs on the next falling edge. A slot's low-half results are read half a cycle after the sampling edge, and the high-half results one full cycle later. Between those two reads the inputs are scrambled, so any leak from the off-slot cycle reaches the compared values.

// File: rtl/df_pkg.sv
package df_pkg;
    // Which half of the held word is due on the next edge
    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } half_e;
endpackage

// File: rtl/df_phase_gen.sv
module df_phase_gen
    import df_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output half_e phase_o
);
    half_e phase_d, phase_q;

    always_comb begin
        phase_d = (phase_q == PH_LO) ? PH_HI : PH_LO;
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_LO;
        else     phase_q <= phase_d;
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/df_half_mux.sv
module df_half_mux #(
    parameter int HALF_W = 20,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              sel_hi,
    input  logic [WORD_W-1:0] word_i,
    output logic [HALF_W-1:0] half_o
);
    for (genvar i = 0; i < HALF_W; i++) begin : g_bit
        assign half_o[i] = sel_hi ? word_i[HALF_W + i] : word_i[i];
    end
endmodule

// File: rtl/df_qual_enc.sv
module df_qual_enc (
    input  logic valid_i,
    input  logic ctrl_i,
    output logic dav_o,
    output logic cav_o
);
    always_comb begin
        dav_o = valid_i & ~ctrl_i;
        cav_o = valid_i &  ctrl_i;
    end
endmodule

// File: rtl/df_interleaver.sv
module df_interleaver
    import df_pkg::*;
#(
    parameter int HALF_W = 20,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] acq_word,
    input  logic              acq_valid,
    input  logic              acq_ctrl,
    output logic              slot_open,
    output logic [HALF_W-1:0] tx_half,
    output logic              tx_flag,
    output logic              tx_dav,
    output logic              tx_cav
);
    typedef struct packed {
        logic [HALF_W-1:0] hold_hi;
        logic [HALF_W-1:0] bus;
        logic              flag;
        logic              dav;
        logic              cav;
    } st_t;

    st_t   st_d, st_q;
    half_e phase;
    logic  enc_dav, enc_cav;
    logic [HALF_W-1:0] mux_half;

    df_phase_gen u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase)
    );

    // Slot cycle: pass the live low half. Other cycle: the held high half.
    df_half_mux #(.HALF_W(HALF_W)) u_mux (
        .sel_hi (phase == PH_HI),
        .word_i ({st_q.hold_hi, acq_word[HALF_W-1:0]}),
        .half_o (mux_half)
    );

    df_qual_enc u_qual (
        .valid_i (acq_valid),
        .ctrl_i  (acq_ctrl),
        .dav_o   (enc_dav),
        .cav_o   (enc_cav)
    );

    always_comb begin
        st_d     = st_q;
        st_d.bus = mux_half;
        if (phase == PH_LO) begin
            st_d.hold_hi = acq_word[WORD_W-1:HALF_W];
            st_d.flag    = 1'b0;
            st_d.dav     = enc_dav;
            st_d.cav     = enc_cav;
        end else begin
            st_d.flag    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign slot_open = (phase == PH_LO);
    assign tx_half   = st_q.bus;
    assign tx_flag   = st_q.flag;
    assign tx_dav    = st_q.dav;
    assign tx_cav    = st_q.cav;
endmodule

module df_interleaver_chk #(
    parameter int HALF_W = 20,
    localparam int WORD_W = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] acq_word,
    input logic              slot_open,
    input logic [HALF_W-1:0] tx_half,
    input logic              tx_flag,
    input logic              tx_dav,
    input logic              tx_cav
);
    a_r4_slot_fall: assert property (@(posedge clk) disable iff (rst)
        slot_open |=> !slot_open);

    a_r4_slot_rise: assert property (@(posedge clk) disable iff (rst)
        !slot_open |=> slot_open);

    a_r4_flag_tracks_slot: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (tx_flag == slot_open));

    a_r2_low_half: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !tx_flag) |-> (tx_half == $past(acq_word[HALF_W-1:0])));

    a_r3_high_half: assert property (@(posedge clk) disable iff (rst)
        tx_flag |-> (tx_half == $past(acq_word[WORD_W-1:HALF_W], 2)));

    a_r5_qual_held: assert property (@(posedge clk) disable iff (rst)
        tx_flag |-> ($stable(tx_dav) && $stable(tx_cav)));

    a_r7_qual_excl: assert property (@(posedge clk) disable iff (rst)
        !(tx_dav && tx_cav));
endmodule

bind df_interleaver df_interleaver_chk #(.HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acq_word  (acq_word),
    .slot_open (slot_open),
    .tx_half   (tx_half),
    .tx_flag   (tx_flag),
    .tx_dav    (tx_dav),
    .tx_cav    (tx_cav)
);

// File: tb/df_interleaver_tb.sv
module df_interleaver_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 20;
    localparam int WW = 2 * HW;
    localparam int NVEC = 6;

    // {word, valid, ctrl, expected dav, expected cav}
    localparam logic [WW+3:0] VEC [NVEC] = '{
        {40'h12345_ABCDE, 1'b1, 1'b0, 1'b1, 1'b0},
        {40'hFFFFF_00000, 1'b1, 1'b1, 1'b0, 1'b1},
        {40'h00000_FFFFF, 1'b0, 1'b0, 1'b0, 1'b0},
        {40'hA5A5A_5A5A5, 1'b0, 1'b1, 1'b0, 1'b0},
        {40'h80001_00001, 1'b1, 1'b0, 1'b1, 1'b0},
        {40'h0F0F0_C3C3C, 1'b1, 1'b1, 1'b0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [WW-1:0] acq_word = '0;
    logic          acq_valid = 1'b0;
    logic          acq_ctrl = 1'b0;
    logic          slot_open;
    logic [HW-1:0] tx_half;
    logic          tx_flag, tx_dav, tx_cav;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    df_interleaver #(.HALF_W(HW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .acq_word  (acq_word),
        .acq_valid (acq_valid),
        .acq_ctrl  (acq_ctrl),
        .slot_open (slot_open),
        .tx_half   (tx_half),
        .tx_flag   (tx_flag),
        .tx_dav    (tx_dav),
        .tx_cav    (tx_cav)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // At a falling edge with slot_open=1: run one word through both halves
    task automatic run_word(input logic [WW-1:0] w, input logic v, input logic c,
                            input logic edav, input logic ecav);
        check("R4 slot open before sample", 64'(slot_open), 64'd1);
        acq_word  = w;
        acq_valid = v;
        acq_ctrl  = c;
        @(negedge clk);
        check("R2 low half", 64'(tx_half), 64'(w[HW-1:0]));
        check("R2 flag low", 64'(tx_flag), 64'd0);
        check("R5 dav first half", 64'(tx_dav), 64'(edav));
        check("R6 cav first half", 64'(tx_cav), 64'(ecav));
        check("R4 slot closed", 64'(slot_open), 64'd0);
        // scramble inputs while the slot is closed
        acq_word  = ~w;
        acq_valid = ~v;
        acq_ctrl  = ~c;
        @(negedge clk);
        check("R3 high half from held copy", 64'(tx_half), 64'(w[WW-1:HW]));
        check("R3 flag high", 64'(tx_flag), 64'd1);
        check("R5 dav second half", 64'(tx_dav), 64'(edav));
        check("R6 cav second half", 64'(tx_cav), 64'(ecav));
        check("R7 qualifiers exclusive", 64'(tx_dav & tx_cav), 64'd0);
        check("R4 flag equals slot_open", 64'(tx_flag), 64'(slot_open));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 half zero", 64'(tx_half), 64'd0);
        check("R1 flag zero", 64'(tx_flag), 64'd0);
        check("R1 dav zero", 64'(tx_dav), 64'd0);
        check("R1 cav zero", 64'(tx_cav), 64'd0);
        check("R1 slot open", 64'(slot_open), 64'd1);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            run_word(VEC[i][WW+3:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R8: reset between halves
        acq_word  = 40'hDEADB_EEF01;
        acq_valid = 1'b1;
        acq_ctrl  = 1'b1;
        @(negedge clk);
        check("R8 pre-reset low half", 64'(tx_half), 64'h EEF01);
        rst = 1'b1;
        @(negedge clk);
        check("R8 R1 reset clears half", 64'(tx_half), 64'd0);
        check("R8 R1 reset clears flag", 64'(tx_flag), 64'd0);
        check("R8 R1 reset clears cav", 64'(tx_cav), 64'd0);
        check("R8 slot open after reset", 64'(slot_open), 64'd1);
        rst = 1'b0;
        acq_word  = 40'h13579_2468A;
        acq_valid = 1'b1;
        acq_ctrl  = 1'b0;
        @(negedge clk);
        check("R8 first half after reset is low", 64'(tx_half), 64'h2468A);
        check("R8 first flag after reset", 64'(tx_flag), 64'd0);
        check("R8 R5 dav after reset", 64'(tx_dav), 64'd1);
        @(negedge clk);
        check("R8 high half after reset", 64'(tx_half), 64'h13579);

        // R7: invalid control word right after a valid one
        run_word(40'h11111_22222, 1'b1, 1'b1, 1'b0, 1'b1);
        run_word(40'h33333_44444, 1'b0, 1'b1, 1'b0, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule